// File: doc/BRIEF.md
# Interrupt and Restart Call Sequencer

This block is the control slice of an 8-bit processor that handles interrupt acceptance and the one-byte restart calls. It keeps the interrupt-enable flag, which the enable and disable instructions set and clear. It latches interrupt requests so that none is lost. At each instruction boundary it decides whether to take a request. For both restart opcodes and accepted interrupts it runs the same three-cycle call sequence: it writes the return address onto the stack as two bytes through the stack pointer, hands a new stack pointer back, and then loads the program counter with the call target.

The core reports each completed instruction by pulsing `instr_done`. With that pulse it gives a kind code, the restart number, the address of the following instruction and the current stack pointer. While `busy` is high the core waits. After a halt instruction the sequencer sits in a halted state until it can accept an interrupt. Returning from a handler uses the core's normal return, which is outside this block.

Top module: `irq_restart_seq`

## Requirements
- R1: After reset the enable flag is 0, no request is pending, `halted`, `busy`, `mem_we`, `int_ack`, `sp_load` and `pc_load` are all 0.
- R2: `instr_kind` uses these codes: 0 other, 1 enable, 2 disable, 3 restart, 4 halt. A boundary with code 1 sets `int_en` from the next cycle. A boundary with code 2 clears it.
- R3: An enable takes effect only after the instruction that follows it. A request pending at the enable boundary itself is not accepted there. It is accepted at the next boundary.
- R4: A request pulse on `irq_req` that arrives while `int_en` is 0 is held pending. It is accepted at the first boundary where the enable is in effect, and no call starts before then.
- R5: Accepting an interrupt raises `int_ack` for exactly one cycle, the first push cycle, and `int_en` is 0 from the following cycle.
- R6: A call writes the high byte of the return address at SP-1 in its first cycle and the low byte at SP-2 in its second cycle. In the third cycle `sp_load` is high with `sp_next` = SP-2.
- R7: In the third cycle of an interrupt call, `pc_load` is high. `pc_target` is then the zero-extended `vec_byte`, which is sampled in the cycle after `int_ack`.
- R8: A restart boundary with number n (0..7) calls address n*8 (0x0000 to 0x0038). It does not raise `int_ack` and leaves `int_en` unchanged.
- R9: When a restart and an acceptable interrupt meet at one boundary, the restart call runs first. The interrupt is accepted at the next boundary.
- R10: A disable boundary blocks acceptance at that same boundary, even if the enable was in effect. The request stays pending.
- R11: A halt boundary raises `halted` until an interrupt is accepted. The pushed return address is the `next_pc` given with the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_done | input | 1 | Instruction boundary strobe |
| instr_kind | input | 3 | Kind of completed instruction (R2 codes) |
| rst_num | input | 3 | Restart number for kind 3 |
| next_pc | input | 16 | Address of the following instruction |
| sp_cur | input | 16 | Current stack pointer |
| irq_req | input | 1 | Interrupt request |
| vec_byte | input | 8 | Vector from the interrupting device |
| int_ack | output | 1 | Interrupt acknowledge |
| int_en | output | 1 | Interrupt enable flag |
| halted | output | 1 | Halted state |
| busy | output | 1 | Call sequence running |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| sp_load | output | 1 | Load stack pointer |
| sp_next | output | 16 | New stack pointer |
| pc_load | output | 1 | Load program counter |
| pc_target | output | 16 | New program counter |

## Verification
A restart opcode and a pending, enabled interrupt can both claim the same instruction boundary. The bench provokes this by latching a request while the enable is in effect and then completing a restart instruction. It judges the outcome from the sequence that follows. The first call must target the restart address with no acknowledge. The next boundary must start an acknowledged call to the device vector, pushing the return address given there. A disable or enable instruction completing while a request is pending is the second collision, and the bench checks that the call starts only at the boundary the requirements name.

// File: rtl/irs_pkg.sv
package irs_pkg;
   typedef enum logic [2:0] {
      KIND_OTHER = 3'd0,
      KIND_EI    = 3'd1,
      KIND_DI    = 3'd2,
      KIND_RST   = 3'd3,
      KIND_HLT   = 3'd4
   } kind_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HALT = 3'd1,
      ST_PHI  = 3'd2,
      ST_PLO  = 3'd3,
      ST_JMP  = 3'd4
   } seq_state_t;
endpackage

// File: rtl/irs_gate.sv
module irs_gate
   import irs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  instr_done,
   input  kind_t kind,
   input  logic  irq_req,
   input  logic  accept,
   input  logic  ack,
   output logic  ie,
   output logic  take
);
   logic ie_q, pend_q;
   logic di_now, ei_now, pend_any;

   assign di_now   = instr_done && (kind == KIND_DI);
   assign ei_now   = instr_done && (kind == KIND_EI);
   assign pend_any = pend_q | irq_req;
   // enable register is read before this boundary's own EI lands
   assign take     = ie_q && pend_any && !di_now;
   assign ie       = ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (accept)      ie_q <= 1'b0;
         else if (ei_now) ie_q <= 1'b1;
         else if (di_now) ie_q <= 1'b0;
         pend_q <= ack ? 1'b0 : pend_any;
      end
   end

   AST_ACCEPT_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ie_q); // R5
   AST_ACCEPT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ie_q); // R4
   AST_DI_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      di_now |=> !ie_q); // R2
   AST_DI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      di_now |-> !accept); // R10
   AST_EI_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_now && !accept) |=> ie_q); // R2
endmodule

// File: rtl/irs_vec_target.sv
module irs_vec_target #(
   parameter int ADDR_W     = 16,
   parameter int VEC_W      = 8,
   parameter int NUM_RST    = 8,
   parameter int RST_STRIDE = 8,
   parameter int VEC_MODE   = 0,
   localparam int IDX_W     = $clog2(NUM_RST),
   localparam int STRIDE_SH = $clog2(RST_STRIDE)
) (
   input  logic [IDX_W-1:0]  rst_num,
   input  logic [VEC_W-1:0]  vec,
   output logic [ADDR_W-1:0] rst_addr,
   output logic [ADDR_W-1:0] vec_addr
);
   if ((1 << STRIDE_SH) != RST_STRIDE) begin : g_bad_stride
      $error("restart stride must be a power of two");
   end
   if (VEC_W > ADDR_W) begin : g_bad_vec
      $error("vector wider than address");
   end

   assign rst_addr = {{(ADDR_W-IDX_W){1'b0}}, rst_num} << STRIDE_SH;

   if (VEC_MODE == 0) begin : g_vec_direct
      // device byte is the low part of the handler address
      assign vec_addr = {{(ADDR_W-VEC_W){1'b0}}, vec};
   end else begin : g_vec_restart
      // device byte carries a restart number in the stride field
      logic [IDX_W-1:0] vidx;
      assign vidx     = vec[STRIDE_SH +: IDX_W];
      assign vec_addr = {{(ADDR_W-IDX_W){1'b0}}, vidx} << STRIDE_SH;
   end
endmodule

// File: rtl/irs_push_seq.sv
module irs_push_seq
   import irs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   localparam int STEP  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_done,
   input  kind_t             kind,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic [ADDR_W-1:0] sp_cur,
   input  logic              take,
   input  logic [ADDR_W-1:0] rst_addr,
   input  logic [ADDR_W-1:0] vec_addr,
   output logic              accept,
   output logic              int_ack,
   output logic              halted,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              sp_load,
   output logic [ADDR_W-1:0] sp_next,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_target
);
   seq_state_t        st_q;
   logic [ADDR_W-1:0] ret_q, sp_q, tgt_q;
   logic              is_int_q;
   logic              start_rst, idle_take, halt_take, go_halt;

   assign start_rst = (st_q == ST_IDLE) && instr_done && (kind == KIND_RST);
   assign idle_take = (st_q == ST_IDLE) && instr_done && (kind != KIND_RST) && take;
   assign halt_take = (st_q == ST_HALT) && take;
   assign go_halt   = (st_q == ST_IDLE) && instr_done && (kind == KIND_HLT) && !take;
   assign accept    = idle_take || halt_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         ret_q    <= '0;
         sp_q     <= '0;
         tgt_q    <= '0;
         is_int_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_rst || idle_take) begin
                  st_q     <= ST_PHI;
                  ret_q    <= next_pc;
                  sp_q     <= sp_cur;
                  tgt_q    <= rst_addr;
                  is_int_q <= idle_take;
               end else if (go_halt) begin
                  st_q  <= ST_HALT;
                  ret_q <= next_pc;
               end
            end
            ST_HALT: begin
               if (halt_take) begin
                  st_q     <= ST_PHI;
                  sp_q     <= sp_cur;
                  is_int_q <= 1'b1;
               end
            end
            ST_PHI: st_q <= ST_PLO;
            ST_PLO: begin
               st_q <= ST_JMP;
               if (is_int_q) tgt_q <= vec_addr;
            end
            ST_JMP:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = (st_q == ST_PHI) || (st_q == ST_PLO);
      mem_addr  = (st_q == ST_PHI) ? sp_q - ADDR_W'(STEP) : sp_q - ADDR_W'(2*STEP);
      mem_wdata = (st_q == ST_PHI) ? ret_q[ADDR_W-1 -: DATA_W] : ret_q[DATA_W-1:0];
      int_ack   = (st_q == ST_PHI) && is_int_q;
      sp_load   = (st_q == ST_JMP);
      sp_next   = sp_q - ADDR_W'(2*STEP);
      pc_load   = (st_q == ST_JMP);
      pc_target = tgt_q;
      halted    = (st_q == ST_HALT);
      busy      = (st_q == ST_PHI) || (st_q == ST_PLO) || (st_q == ST_JMP);
   end

   AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PHI) |=> (mem_we && mem_addr == $past(mem_addr) - ADDR_W'(STEP))); // R6
   AST_SP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      sp_load |-> (sp_next == $past(mem_addr) && $past(mem_we))); // R6
   AST_JUMP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> $past(mem_we, 2)); // R7
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !take) |=> halted); // R11
   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !int_ack); // R5
endmodule

// File: rtl/irq_restart_seq.sv
module irq_restart_seq
   import irs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int NUM_RST    = 8,
   parameter int RST_STRIDE = 8,
   parameter int VEC_MODE   = 0,
   localparam int IDX_W     = $clog2(NUM_RST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_done,
   input  logic [2:0]        instr_kind,
   input  logic [IDX_W-1:0]  rst_num,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic [ADDR_W-1:0] sp_cur,
   input  logic              irq_req,
   input  logic [DATA_W-1:0] vec_byte,
   output logic              int_ack,
   output logic              int_en,
   output logic              halted,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              sp_load,
   output logic [ADDR_W-1:0] sp_next,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_target
);
   if (ADDR_W != 2*DATA_W) begin : g_bad_width
      $error("return address must be exactly two stack bytes");
   end

   kind_t             kind;
   logic              take, accept;
   logic [ADDR_W-1:0] rst_addr, vec_addr;

   assign kind = kind_t'(instr_kind);

   irs_gate u_gate (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .kind(kind),
      .irq_req(irq_req), .accept(accept), .ack(int_ack),
      .ie(int_en), .take(take)
   );

   irs_vec_target #(
      .ADDR_W(ADDR_W), .VEC_W(DATA_W), .NUM_RST(NUM_RST),
      .RST_STRIDE(RST_STRIDE), .VEC_MODE(VEC_MODE)
   ) u_tgt (
      .rst_num(rst_num), .vec(vec_byte),
      .rst_addr(rst_addr), .vec_addr(vec_addr)
   );

   irs_push_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .kind(kind),
      .next_pc(next_pc), .sp_cur(sp_cur), .take(take),
      .rst_addr(rst_addr), .vec_addr(vec_addr),
      .accept(accept), .int_ack(int_ack), .halted(halted), .busy(busy),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .sp_load(sp_load), .sp_next(sp_next),
      .pc_load(pc_load), .pc_target(pc_target)
   );

   AST_RESTART_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !$past(int_ack, 2)) |->
      (pc_target % RST_STRIDE == 0 && pc_target < ADDR_W'(NUM_RST*RST_STRIDE))); // R8
endmodule

// File: tb/irq_restart_seq_test.sv
module irq_restart_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_done = 1'b0;
   logic [2:0]  instr_kind = 3'd0;
   logic [2:0]  rst_num = 3'd0;
   logic [15:0] next_pc = 16'h0;
   logic [15:0] sp_cur = 16'h0;
   logic        irq_req = 1'b0;
   logic [7:0]  vec_byte = 8'h0;
   logic        int_ack, int_en, halted, busy, mem_we, sp_load, pc_load;
   logic [15:0] mem_addr, sp_next, pc_target;
   logic [7:0]  mem_wdata;

   int checks = 0;
   int errors = 0;

   localparam logic [2:0] K_OTHER = 3'd0, K_EI = 3'd1, K_DI = 3'd2,
                          K_RST = 3'd3, K_HLT = 3'd4;

   always #5 clk = ~clk;

   irq_restart_seq uut (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .instr_kind(instr_kind),
      .rst_num(rst_num), .next_pc(next_pc), .sp_cur(sp_cur), .irq_req(irq_req),
      .vec_byte(vec_byte), .int_ack(int_ack), .int_en(int_en), .halted(halted),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .sp_load(sp_load), .sp_next(sp_next), .pc_load(pc_load), .pc_target(pc_target)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic boundary(logic [2:0] k, logic [2:0] n, logic [15:0] npc, logic [15:0] sp);
      @(negedge clk);
      instr_done = 1'b1; instr_kind = k; rst_num = n; next_pc = npc; sp_cur = sp;
      @(negedge clk);
      instr_done = 1'b0; instr_kind = K_OTHER;
   endtask

   task automatic pulse_irq();
      @(negedge clk); irq_req = 1'b1;
      @(negedge clk); irq_req = 1'b0;
   endtask

   task automatic expect_push(string r, logic [15:0] ret, logic [15:0] sp,
                              logic isint, logic [7:0] vb, logic [15:0] tgt);
      vec_byte = vb;
      check({r, " R6 hi we"}, mem_we, 1);
      check({r, " R6 hi addr"}, mem_addr, sp - 16'd1);
      check({r, " R6 hi data"}, mem_wdata, ret[15:8]);
      check({r, " R5 ack"}, int_ack, isint);
      @(negedge clk);
      check({r, " R6 lo we"}, mem_we, 1);
      check({r, " R6 lo addr"}, mem_addr, sp - 16'd2);
      check({r, " R6 lo data"}, mem_wdata, ret[7:0]);
      check({r, " R5 ack single"}, int_ack, 0);
      if (isint) check({r, " R5 ie cleared"}, int_en, 0);
      @(negedge clk);
      check({r, " R7 pc_load"}, pc_load, 1);
      check({r, " R7 target"}, pc_target, tgt);
      check({r, " R6 sp_load"}, sp_load, 1);
      check({r, " R6 sp_next"}, sp_next, sp - 16'd2);
      check({r, " R6 no write"}, mem_we, 0);
      @(negedge clk);
      check({r, " done busy"}, busy, 0);
      check({r, " done pc_load"}, pc_load, 0);
   endtask

   task automatic t_reset();
      check("R1 int_en", int_en, 0);
      check("R1 halted", halted, 0);
      check("R1 busy", busy, 0);
      check("R1 mem_we", mem_we, 0);
      check("R1 int_ack", int_ack, 0);
      check("R1 pc_load", pc_load, 0);
      check("R1 sp_load", sp_load, 0);
   endtask

   task automatic t_ei_di();
      boundary(K_EI, 0, 16'h0101, 16'h2000);
      check("R2 ei sets", int_en, 1);
      boundary(K_DI, 0, 16'h0102, 16'h2000);
      check("R2 di clears", int_en, 0);
   endtask

   task automatic t_pending();
      pulse_irq();
      boundary(K_OTHER, 0, 16'h0200, 16'h3000);
      check("R4 no call while disabled", mem_we, 0);
      check("R4 idle", busy, 0);
      boundary(K_EI, 0, 16'h0201, 16'h3000);
      check("R3 no call at ei boundary", mem_we, 0);
      check("R3 ei took effect", int_en, 1);
      boundary(K_OTHER, 0, 16'h4567, 16'h3000);
      expect_push("R4 R7 held request", 16'h4567, 16'h3000, 1, 8'h5A, 16'h005A);
   endtask

   task automatic t_restart();
      boundary(K_EI, 0, 16'h0300, 16'h2000);
      boundary(K_OTHER, 0, 16'h0301, 16'h2000);
      boundary(K_RST, 3'd5, 16'h1234, 16'h2000);
      expect_push("R8 rst5", 16'h1234, 16'h2000, 0, 8'h00, 16'h0028);
      check("R8 ie kept", int_en, 1);
      boundary(K_RST, 3'd0, 16'h0029, 16'h1FFE);
      expect_push("R8 rst0", 16'h0029, 16'h1FFE, 0, 8'h00, 16'h0000);
      boundary(K_RST, 3'd7, 16'hABCD, 16'h1FFC);
      expect_push("R8 rst7", 16'hABCD, 16'h1FFC, 0, 8'h00, 16'h0038);
   endtask

   task automatic t_collide();
      pulse_irq();
      check("R9 no call without boundary", mem_we, 0);
      boundary(K_RST, 3'd3, 16'h0800, 16'h2000);
      expect_push("R9 restart first", 16'h0800, 16'h2000, 0, 8'h00, 16'h0018);
      boundary(K_OTHER, 0, 16'h0019, 16'h1FFE);
      expect_push("R9 interrupt next", 16'h0019, 16'h1FFE, 1, 8'h77, 16'h0077);
   endtask

   task automatic t_di_block();
      boundary(K_EI, 0, 16'h0500, 16'h2000);
      boundary(K_OTHER, 0, 16'h0501, 16'h2000);
      pulse_irq();
      boundary(K_DI, 0, 16'h0502, 16'h2000);
      check("R10 no call at di", mem_we, 0);
      check("R10 ie cleared", int_en, 0);
      boundary(K_OTHER, 0, 16'h0503, 16'h2000);
      check("R10 still blocked", mem_we, 0);
      boundary(K_EI, 0, 16'h0504, 16'h2000);
      check("R10 R3 not at ei", mem_we, 0);
      boundary(K_OTHER, 0, 16'h0505, 16'h2000);
      expect_push("R10 kept pending", 16'h0505, 16'h2000, 1, 8'hC3, 16'h00C3);
   endtask

   task automatic t_halt();
      boundary(K_EI, 0, 16'h0600, 16'h2400);
      boundary(K_OTHER, 0, 16'h0601, 16'h2400);
      boundary(K_HLT, 0, 16'h0301, 16'h2400);
      check("R11 halted", halted, 1);
      check("R11 no write", mem_we, 0);
      repeat (3) @(negedge clk);
      check("R11 stays halted", halted, 1);
      @(negedge clk); irq_req = 1'b1;
      @(negedge clk); irq_req = 1'b0;
      check("R11 left halt", halted, 0);
      expect_push("R11 resume", 16'h0301, 16'h2400, 1, 8'h40, 16'h0040);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ei_di();
      t_pending();
      t_restart();
      t_collide();
      t_di_block();
      t_halt();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule